// File: doc/BRIEF.md
# Idle-Mode Clock Domain Controller

This controller decides which clock domains of a small processor system are enabled. It separates the CPU clock enable from the peripheral clock enable. It also tracks which oscillator feeds the system: the primary oscillator, a low-frequency secondary oscillator, or an internal clock. A control register holds an idle-enable bit and a 2-bit source-select field. Together they choose the run source. At a sleep strobe they also decide whether the CPU is parked in an idle state while the peripherals keep running.

A wake event starts a fixed clock-switch delay, counted in cycles. Once the delay expires, the CPU resumes from the same source that fed the peripherals while the CPU was idle. Waking never alters the control register or the selected source. A sleep strobe with idle disabled is not handled here. The block only reports it on a one-cycle full-sleep output.

Top module: `pm_idle_ctrl`

## Requirements
- R1: After synchronous reset the block is running from the primary source. cpu_clk_en=1, per_clk_en=1, sel_pri=1, sel_sec=0, pri_stable=1, sec_in_use=0, pri_off_req=0, full_sleep=0, idle_en_q=0 and clk_sel_q=00.
- R2: A sleep strobe with idle_en_q=1 and clk_sel_q=00 enters primary idle. cpu_clk_en drops and per_clk_en stays high. sel_pri and pri_stable stay 1, and pri_off_req stays 0.
- R3: A sleep strobe with idle_en_q=1, clk_sel_q=01 and sec_osc_en=1 enters secondary idle. cpu_clk_en drops, sel_sec=1, sel_pri=0, pri_off_req=1, pri_stable=0 and sec_in_use=1.
- R4: A request for the secondary source (a control write or a sleep strobe with clk_sel 01) is ignored while sec_osc_en=0. The block stays running (cpu_clk_en=1) on its previous source.
- R5: While the secondary source is selected, per_clk_en is low whenever sec_ready is low, and high when sec_ready is high.
- R6: A wake event sampled in idle raises cpu_clk_en exactly DELAY clock edges later. A wake event during that wait does not restart the count.
- R7: Waking does not change idle_en_q, clk_sel_q or the selected source flags (sel_pri, sel_sec, pri_stable, sec_in_use).
- R8: A sleep strobe with idle_en_q=0 gives a one-cycle full_sleep pulse on the next edge and changes no other output.
- R9: A sleep strobe with idle_en_q=1 and clk_sel_q=10 or 11 enters internal idle. cpu_clk_en=0, per_clk_en=1, and sel_pri, sel_sec, pri_stable and pri_off_req are all 0.
- R10: A control write (ctl_we) while running selects the run source on the next edge. 00 selects primary, 01 selects secondary only if sec_osc_en=1, and 1x selects internal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| idle_en_d | input | 1 | Idle-enable value to write |
| clk_sel_d | input | 2 | Source-select value to write |
| sec_osc_en | input | 1 | Secondary oscillator enabled |
| sec_ready | input | 1 | Secondary oscillator running and stable |
| sleep_req | input | 1 | Sleep request strobe |
| wake | input | 1 | Wake event |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| sel_pri | output | 1 | Primary source selected |
| sel_sec | output | 1 | Secondary source selected |
| pri_off_req | output | 1 | Request to stop the primary oscillator |
| pri_stable | output | 1 | Primary oscillator start-up complete flag |
| sec_in_use | output | 1 | System clocked from secondary source |
| full_sleep | output | 1 | One-cycle full-sleep indication |
| idle_en_q | output | 1 | Stored idle-enable bit |
| clk_sel_q | output | 2 | Stored source-select field |

## Verification
The assertions assume that the inputs change only between clock edges and that the sleep strobe and control write are never raised in the same cycle. They also assume that DELAY is at least 1. The bench drives every input on the falling edge and pulses sleep_req, ctl_we and wake for a single cycle each, never together. It sweeps all combinations of the idle bit, the select field and the secondary enable. Expected outcomes come from the requirement rules alone.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IDLE = 2'd1,
        ST_WAKE = 2'd2
    } pm_state_e;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_SEC = 2'd1,
        SRC_INT = 2'd2
    } pm_src_e;

    typedef struct packed {
        logic       idle_en;
        logic [1:0] clk_sel;
    } pm_ctl_t;

    // Map a select field to a source; secondary only when its oscillator is enabled.
    function automatic pm_src_e sel_to_src(input logic [1:0] sel,
                                           input logic       sec_en,
                                           input pm_src_e    cur);
        pm_src_e r;
        if (sel[1])
            r = SRC_INT;
        else if (sel[0])
            r = sec_en ? SRC_SEC : cur;
        else
            r = SRC_PRI;
        return r;
    endfunction

endpackage

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg
    import pm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  pm_ctl_t wdata,
    output pm_ctl_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= wdata;
    end

    // R7
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/pm_wake_timer.sv
module pm_wake_timer #(
    parameter int DELAY = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
    localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= LOAD;
            end
        end else if (cnt == '0) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt <= LOAD);

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import pm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pm_ctl_t   ctl,
    input  logic      ctl_we,
    input  pm_ctl_t   ctl_wdata,
    input  logic      sec_osc_en,
    input  logic      sleep_req,
    input  logic      wake,
    input  logic      tmr_done,
    output logic      tmr_start,
    output pm_state_e state,
    output pm_src_e   src,
    output logic      full_sleep
);
    pm_state_e state_n;
    pm_src_e   src_n;
    logic      full_n;

    always_comb begin
        state_n   = state;
        src_n     = src;
        full_n    = 1'b0;
        tmr_start = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (sleep_req) begin
                    if (!ctl.idle_en) begin
                        full_n = 1'b1;
                    end else if (ctl.clk_sel == 2'b01 && !sec_osc_en) begin
                        state_n = ST_RUN;
                    end else begin
                        state_n = ST_IDLE;
                        src_n   = sel_to_src(ctl.clk_sel, sec_osc_en, src);
                    end
                end else if (ctl_we) begin
                    src_n = sel_to_src(ctl_wdata.clk_sel, sec_osc_en, src);
                end
            end
            ST_IDLE: begin
                if (wake) begin
                    state_n   = ST_WAKE;
                    tmr_start = 1'b1;
                end
            end
            ST_WAKE: begin
                if (tmr_done)
                    state_n = ST_RUN;
            end
            default: state_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            src        <= SRC_PRI;
            full_sleep <= 1'b0;
        end else begin
            state      <= state_n;
            src        <= src_n;
            full_sleep <= full_n;
        end
    end

    // R7
    wake_src_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |=> $stable(src));

    // R8
    full_sleep_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        full_sleep |=> !full_sleep);

endmodule

// File: rtl/pm_idle_ctrl.sv
module pm_idle_ctrl
    import pm_pkg::*;
#(
    parameter int DELAY = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic       idle_en_d,
    input  logic [1:0] clk_sel_d,
    input  logic       sec_osc_en,
    input  logic       sec_ready,
    input  logic       sleep_req,
    input  logic       wake,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       sel_pri,
    output logic       sel_sec,
    output logic       pri_off_req,
    output logic       pri_stable,
    output logic       sec_in_use,
    output logic       full_sleep,
    output logic       idle_en_q,
    output logic [1:0] clk_sel_q
);
    pm_ctl_t   ctl_q;
    pm_ctl_t   ctl_w;
    pm_state_e state;
    pm_src_e   src;
    logic      tmr_start;
    logic      tmr_busy;
    logic      tmr_done;

    assign ctl_w = '{idle_en: idle_en_d, clk_sel: clk_sel_d};

    pm_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_w),
        .q     (ctl_q)
    );

    pm_wake_timer #(.DELAY(DELAY)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    pm_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl_q),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_w),
        .sec_osc_en (sec_osc_en),
        .sleep_req  (sleep_req),
        .wake       (wake),
        .tmr_done   (tmr_done),
        .tmr_start  (tmr_start),
        .state      (state),
        .src        (src),
        .full_sleep (full_sleep)
    );

    assign cpu_clk_en  = (state == ST_RUN);
    assign sel_pri     = (src == SRC_PRI);
    assign sel_sec     = (src == SRC_SEC);
    assign pri_off_req = (src == SRC_SEC);
    assign sec_in_use  = (src == SRC_SEC);
    assign pri_stable  = (src == SRC_PRI);
    assign per_clk_en  = (src != SRC_SEC) || sec_ready;
    assign idle_en_q   = ctl_q.idle_en;
    assign clk_sel_q   = ctl_q.clk_sel;

    // R6
    cpu_vs_timer_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> !tmr_busy);

    // R2
    pri_idle_osc_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && sel_pri) |-> (pri_stable && !pri_off_req && per_clk_en));

    // R4
    sec_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && sleep_req && idle_en_q && clk_sel_q == 2'b01 && !sec_osc_en)
        |=> (cpu_clk_en && $stable(src)));

    // R5
    sec_ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_sec && !sec_ready) |-> !per_clk_en);

endmodule

// File: tb/tb_pm_idle_ctrl.sv
module tb_pm_idle_ctrl;
    localparam int D = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic       idle_en_d = 1'b0;
    logic [1:0] clk_sel_d = 2'b00;
    logic       sec_osc_en = 1'b0;
    logic       sec_ready = 1'b1;
    logic       sleep_req = 1'b0;
    logic       wake = 1'b0;
    logic       cpu_clk_en, per_clk_en, sel_pri, sel_sec, pri_off_req;
    logic       pri_stable, sec_in_use, full_sleep, idle_en_q;
    logic [1:0] clk_sel_q;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    pm_idle_ctrl #(.DELAY(D)) dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .idle_en_d(idle_en_d),
        .clk_sel_d(clk_sel_d), .sec_osc_en(sec_osc_en), .sec_ready(sec_ready),
        .sleep_req(sleep_req), .wake(wake), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .sel_pri(sel_pri), .sel_sec(sel_sec),
        .pri_off_req(pri_off_req), .pri_stable(pri_stable),
        .sec_in_use(sec_in_use), .full_sleep(full_sleep),
        .idle_en_q(idle_en_q), .clk_sel_q(clk_sel_q)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // src code: 0 primary, 1 secondary, 2 internal
    task automatic chk_src(input string req, input int s);
        chk(req, {4'd0, sel_pri, sel_sec, pri_stable, sec_in_use},
            {4'd0, s == 0, s == 1, s == 0, s == 1});
        chk(req, {7'd0, pri_off_req}, {7'd0, s == 1});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        for (int ie = 0; ie < 2; ie++) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int en = 0; en < 2; en++) begin
                    int  run_src;
                    int  idle_src;
                    bit  go_idle;
                    @(negedge clk);
                    rst = 1'b1; sec_ready = 1'b1;
                    @(negedge clk);
                    @(negedge clk);
                    rst = 1'b0;
                    @(negedge clk);
                    // R1 reset state
                    chk("R1", {cpu_clk_en, per_clk_en, full_sleep, idle_en_q, clk_sel_q, 2'b00},
                        {1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00});
                    chk_src("R1", 0);

                    ctl_we = 1'b1; idle_en_d = ie[0]; clk_sel_d = sel[1:0];
                    sec_osc_en = en[0];
                    @(negedge clk);
                    ctl_we = 1'b0;
                    run_src = (sel >= 2) ? 2 : (sel == 1 && en == 1) ? 1 : 0;
                    // R10 write picks run source
                    chk("R10", {7'd0, cpu_clk_en}, 8'd1);
                    chk_src("R10", run_src);
                    chk("R10", {5'd0, idle_en_q, clk_sel_q}, {5'd0, ie[0], sel[1:0]});

                    sleep_req = 1'b1;
                    @(negedge clk);
                    sleep_req = 1'b0;
                    go_idle  = (ie == 1) && !(sel == 1 && en == 0);
                    idle_src = go_idle ? ((sel >= 2) ? 2 : sel) : run_src;
                    // R8 full-sleep pulse when idle disabled
                    chk("R8", {7'd0, full_sleep}, {7'd0, ie == 0});
                    chk("R8", {7'd0, cpu_clk_en}, {7'd0, !go_idle});
                    if (sel == 1 && en == 0 && ie == 1)
                        chk("R4", {7'd0, cpu_clk_en}, 8'd1);
                    if (sel == 0) chk("R2", {7'd0, per_clk_en}, 8'd1);
                    if (sel >= 2) chk("R9", {7'd0, per_clk_en}, 8'd1);
                    chk_src(go_idle ? (sel == 0 ? "R2" : sel == 1 ? "R3" : "R9") : "R4", idle_src);
                    @(negedge clk);
                    chk("R8", {7'd0, full_sleep}, 8'd0);

                    if (idle_src == 1) begin
                        sec_ready = 1'b0;
                        @(negedge clk);
                        chk("R5", {7'd0, per_clk_en}, 8'd0);
                        sec_ready = 1'b1;
                        @(negedge clk);
                        chk("R5", {7'd0, per_clk_en}, 8'd1);
                    end

                    if (go_idle) begin
                        wake = 1'b1;
                        @(negedge clk);
                        wake = 1'b0;
                        // j counts edges after the one that sampled wake
                        for (int j = 0; j <= D; j++) begin
                            chk("R6", {7'd0, cpu_clk_en}, {7'd0, j == D});
                            if (j == 1) wake = 1'b1;
                            @(negedge clk);
                            wake = 1'b0;
                        end
                        chk("R6", {7'd0, cpu_clk_en}, 8'd1);
                        // R7 wake preserves control and source
                        chk("R7", {5'd0, idle_en_q, clk_sel_q}, {5'd0, ie[0], sel[1:0]});
                        chk_src("R7", idle_src);
                    end
                end
            end
        end
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule